// File: doc/BRIEF.md
# Multi-channel ADC capture sequencer

This block captures three simultaneously converting ADC channels, all on one fast system clock. A modulo-5 counter produces a one-cycle sample enable. With a 50 MHz clock this gives the 10 MHz sample rate. Each period is a 5-cycle window. No divided or gated clock is made: the enable alone paces the capture logic.

After each enable, a small sequencer reads channel 0, then channel 1, then channel 2, one per cycle. Each channel is read exactly once per window, and the last two cycles of the window are idle. Every captured value is tagged with its channel number and written into an 8-word buffer. A downstream burst writer reads words from the buffer's head. The block raises burst-ready once a 4-word group is waiting, and the writer pulses an acknowledge after it has taken the group. A capture that finds the buffer full is dropped, and a sticky overflow flag records the loss.

Top module: `adc_capture_seq`

## Requirements
- R1: Driving rst_n low clears the block at once: buf_empty is high, and burst_ready, overflow and sample_en are low. After rst_n rises, the block becomes active from the third rising clock edge on.
- R2: sample_en is high for one cycle in every 5. It is first high in the cycle after the fifth active edge.
- R3: The sequencer captures one word on each of the three edges that close the cycles following a sample_en cycle. It takes channel 0, then channel 1, then channel 2. The other two cycles of the window capture nothing.
- R4: A buffered word is 14 bits wide. Bits [13:12] hold the channel number (0, 1 or 2), and bits [11:0] hold that channel's ADC value at the capturing edge.
- R5: While buf_empty is low, rd_data shows the oldest word, and rd_en at an edge removes it. rd_en while the buffer is empty has no effect.
- R6: burst_ready becomes set at an edge that starts with 4 or more words in the buffer. It stays set until an edge with burst_ack high, which clears it. The flag is then evaluated again from the next edge on.
- R7: The buffer holds 8 words. A capture due while it is full is dropped, even if a read happens at the same edge. Words already stored stay unchanged.
- R8: overflow becomes set at the edge of a dropped capture and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| adc_ch0 | input | 12 | Channel 0 ADC data |
| adc_ch1 | input | 12 | Channel 1 ADC data |
| adc_ch2 | input | 12 | Channel 2 ADC data |
| sample_en | output | 1 | One-cycle sample-period enable |
| rd_en | input | 1 | Remove the head word of the buffer |
| rd_data | output | 14 | Head word: channel tag in [13:12], data in [11:0] |
| buf_empty | output | 1 | Buffer holds no words |
| burst_ready | output | 1 | A burst-length group is waiting |
| burst_ack | input | 1 | Downstream has taken the burst |
| overflow | output | 1 | Sticky flag: a capture was dropped |

## Verification
Every result is due one edge after the event that causes it. A capture, a removal, a burst-ready change and an overflow set each appear in the cycle after the edge where they occur. The exception is sample_en: it lags the counter's final count by one registered edge. The bench counts active edges from reset release and predicts each edge's effect from those counts. It makes the prediction in the low phase before that edge. It then compares the outputs in the low phase after that edge, so every sample falls exactly one register stage after the stimulus it depends on.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int CH_W = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/cap_tick_gen.sv
module cap_tick_gen #(
  parameter int WINDOW = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    tick_d = (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/cap_chan_seq.sv
module cap_chan_seq
  import adc_cap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  adc_bus,
  output logic                           wr_en,
  output logic [CH_W+DATA_W-1:0]         wr_word
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    case (state_q)
      SEQ_IDLE: begin
        if (tick) begin
          state_d = SEQ_SCAN;
          ch_d    = '0;
        end
      end
      SEQ_SCAN: begin
        if (ch_q == LAST_CH) begin
          state_d = SEQ_IDLE;
          ch_d    = '0;
        end else begin
          ch_d = ch_q + 1'b1;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        ch_d    = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  assign wr_en   = (state_q == SEQ_SCAN);
  assign wr_word = {ch_q, adc_bus[ch_q]};

  // R3
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (wr_en && ch_q == '0));
  // R3
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ch_q == LAST_CH) |=> !wr_en);
  // R3
  idle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !wr_en);
endmodule

// File: rtl/cap_word_fifo.sv
module cap_word_fifo #(
  parameter int WORD_W = 14,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              empty,
  input  logic              burst_ack,
  output logic              burst_ready,
  output logic              overflow
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_BURST = CNT_W'(BURST);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              ovf_q, ovf_d, rdy_q, rdy_d;
  logic              full, wr_ok, rd_ok;

  always_comb begin
    full     = (count_q == CNT_FULL);
    wr_ok    = wr_en && !full;
    rd_ok    = rd_en && (count_q != '0);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (wr_ok) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_ok) rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    if (wr_ok && !rd_ok) count_d = count_q + 1'b1;
    if (rd_ok && !wr_ok) count_d = count_q - 1'b1;
    ovf_d = ovf_q || (wr_en && full);
    rdy_d = burst_ack ? 1'b0 : (rdy_q || (count_q >= CNT_BURST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
      rdy_q    <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_word;
  end

  assign rd_word     = mem[rd_ptr_q];
  assign empty       = (count_q == '0);
  assign burst_ready = rdy_q;
  assign overflow    = ovf_q;

  // R7
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_FULL);
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (count_q == CNT_FULL && $stable(wr_ptr_q)));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ack |=> !rdy_q);
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int WINDOW = 5,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DATA_W-1:0]      adc_ch0,
  input  logic [DATA_W-1:0]      adc_ch1,
  input  logic [DATA_W-1:0]      adc_ch2,
  output logic                   sample_en,
  input  logic                   rd_en,
  output logic [CH_W+DATA_W-1:0] rd_data,
  output logic                   buf_empty,
  output logic                   burst_ready,
  input  logic                   burst_ack,
  output logic                   overflow
);
  localparam int NUM_CH = 3;
  localparam int WORD_W = CH_W + DATA_W;

  logic                          rst_i_n;
  logic                          tick;
  logic [NUM_CH-1:0][DATA_W-1:0] adc_bus;
  logic                          cap_wr;
  logic [WORD_W-1:0]             cap_word;

  assign adc_bus = {adc_ch2, adc_ch1, adc_ch0};

  cap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cap_tick_gen #(.WINDOW(WINDOW)) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (tick)
  );

  cap_chan_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick    (tick),
    .adc_bus (adc_bus),
    .wr_en   (cap_wr),
    .wr_word (cap_word)
  );

  cap_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .BURST(BURST)) u_buf (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .wr_en       (cap_wr),
    .wr_word     (cap_word),
    .rd_en       (rd_en),
    .rd_word     (rd_data),
    .empty       (buf_empty),
    .burst_ack   (burst_ack),
    .burst_ready (burst_ready),
    .overflow    (overflow)
  );

  assign sample_en = tick;
endmodule

// File: tb/tb_adc_capture_seq.sv
module tb_adc_capture_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int BURST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] adc_ch0 = '0, adc_ch1 = '0, adc_ch2 = '0;
  logic        sample_en, rd_en = 1'b0, buf_empty, burst_ready, burst_ack = 1'b0, overflow;
  logic [13:0] rd_data;

  adc_capture_seq dut (
    .clk(clk), .rst_n(rst_n), .adc_ch0(adc_ch0), .adc_ch1(adc_ch1), .adc_ch2(adc_ch2),
    .sample_en(sample_en), .rd_en(rd_en), .rd_data(rd_data), .buf_empty(buf_empty),
    .burst_ready(burst_ready), .burst_ack(burst_ack), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int rel_cnt = 0, ecount = 0;
  int mcnt = 0;
  bit mrdy = 0, movf = 0;
  bit drain_on = 0, ack_req = 0, done = 0;
  logic [13:0] expq[$];
  logic [11:0] seed = 12'h5A3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= 0;
      ecount  <= 0;
    end else begin
      if (rel_cnt < 2) rel_cnt <= rel_cnt + 1;
      if (rel_cnt >= 2) ecount <= ecount + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (edge %0d)", req, act, exp, ecount);
    end
  endtask

  // Driver: new ADC values per window, prediction of the coming edge.
  task automatic drive_and_predict();
    int e, slot;
    bit wr, rd;
    if (ecount >= 5 && ecount % 5 == 0) begin
      seed    = seed * 12'd1103 + 12'd17;
      adc_ch0 = seed;
      adc_ch1 = ~seed;
      adc_ch2 = (ecount % 10 == 0) ? 12'hFFF : 12'h000 ^ {seed[5:0], seed[11:6]};
    end
    rd_en     = drain_on;
    burst_ack = ack_req;
    ack_req   = 0;
    if (rel_cnt < 2) return;
    e    = ecount + 1;
    slot = (e - 7) % 5;
    wr   = (e >= 7) && (slot < 3);
    rd   = rd_en && (mcnt > 0);
    // R6 model: evaluated on occupancy before the edge
    mrdy = burst_ack ? 1'b0 : (mrdy || (mcnt >= BURST));
    if (rd) begin
      void'(expq.pop_front());
      mcnt--;
    end
    if (wr) begin
      // R7: capture dropped when full at the edge, read or not
      if (mcnt + (rd ? 1 : 0) == DEPTH) movf = 1;
      else begin
        case (slot)
          0: expq.push_back({2'd0, adc_ch0});
          1: expq.push_back({2'd1, adc_ch1});
          default: expq.push_back({2'd2, adc_ch2});
        endcase
        mcnt++;
      end
    end
  endtask

  // Monitor: compare outputs one register stage after the predicted edge.
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n || rel_cnt < 2 && ecount == 0 && rel_cnt == 0) begin
        mcnt = 0; mrdy = 0; movf = 0; expq.delete();
      end
      check("R2 sample_en", sample_en, (ecount >= 5 && ecount % 5 == 0));
      check("R5 buf_empty", buf_empty, (mcnt == 0));
      check("R6 burst_ready", burst_ready, mrdy);
      check("R8 overflow", overflow, movf);
      if (mcnt > 0) check("R3/R4 rd_data", rd_data, expq[0]);
      drive_and_predict();
    end
  end

  initial begin
    int i;
    for (i = 0; i < 3; i++) @(posedge clk);
    #1;
    check("R1 reset empty", buf_empty, 1'b1);
    check("R1 reset overflow", overflow, 1'b0);
    check("R1 reset burst_ready", burst_ready, 1'b0);
    rst_n = 1'b1;
    // fill without reading: burst flag and overflow (R6, R7, R8)
    for (i = 0; i < 45; i++) @(posedge clk);
    #1 ack_req = 1;
    for (i = 0; i < 6; i++) @(posedge clk);
    // drain, including reads while empty (R5)
    #1 drain_on = 1;
    for (i = 0; i < 40; i++) @(posedge clk);
    #1 ack_req = 1;
    for (i = 0; i < 20; i++) @(posedge clk);
    // asynchronous reset mid-run (R1)
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear overflow", overflow, 1'b0);
    check("R1 async clear empty", buf_empty, 1'b1);
    for (i = 0; i < 3; i++) @(posedge clk);
    #1 rst_n = 1'b1; drain_on = 0;
    for (i = 0; i < 25; i++) @(posedge clk);
    #1 drain_on = 1;
    for (i = 0; i < 30; i++) @(posedge clk);
    #1 done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule